// File: doc/BRIEF.md
# Sixteen-Pin Bidirectional GPIO Port

This block controls a general-purpose I/O port of configurable width, 16 pins by default. Software sees five per-pin control words over a small register bus with separate write and read strobes. The words set direction, output level, open-drain behaviour and analog selection. For every pin the block produces a pad output value and an output enable, and it takes back a pad input level.

Pad inputs pass through a one-stage sampling register before the port read path can see them. A read therefore sees a pin change, or the effect of a direction change, only after one spare cycle. Pins marked as analog have their digital input gated off, and they always read as zero through the pin address. Their output driver still follows the direction and latch settings.

Top module: `gpio_port`

## Requirements
- R1: While `rst` is high at a clock edge, every direction bit becomes 1 (all pins inputs) and the latch, open-drain and analog words become 0. After reset `pad_oe` is 0 and `rd_data` is 0.
- R2: A direction bit of 1 releases that pin's `pad_oe`. A direction bit of 0 on a pin whose open-drain bit is 0 asserts `pad_oe` and drives `pad_out` with the latch bit.
- R3: On a pin with direction 0 and open-drain bit 1, `pad_out` is 0. `pad_oe` is asserted when the latch bit is 0 and released when it is 1.
- R4: A write to address 1 (latch) or address 2 (pin) loads `wr_data` into the output latch at that clock edge. Writes to address 0 (direction), 3 (open-drain) and 4 (analog) load their own words.
- R5: A read of address 1 returns the latch word, not the pin levels.
- R6: A read of address 2 returns the pad levels captured one clock earlier. A read issued in the same cycle as a pad change, or in the cycle right after a direction or latch write, returns the earlier pin state. A read issued one cycle later returns the new state.
- R7: Pins whose analog bit is 1 read as 0 at address 2, whatever level their pad carries.
- R8: An analog-selected pin with direction 0 still drives its latch bit onto `pad_out`, with `pad_oe` asserted, following R2 and R3.
- R9: Reads return data in `rd_data` on the clock edge that samples `rd_en`, and `rd_data` holds its value while `rd_en` is low. Addresses 5 to 7 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register address (0 direction, 1 latch, 2 pins, 3 open-drain, 4 analog) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| pad_in | input | 16 | Level present on each pad |
| pad_out | output | 16 | Value driven towards each pad |
| pad_oe | output | 16 | Driver enable for each pad |

## Verification
The hardest case to reach from the ports is the stale port read. A read has to land in exactly the cycle where the sampling register and the read register update together, either right after a configuration write or in the same cycle that the pad level moves. The bench wires the pads back through a model of the pad, mixing the block's own drive with an external random level. Directed sequences place a pin read at once after a pad change or a direction write, and again one cycle later. Random sequences then combine all four control words, with idle cycles inserted before each compared pin read.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W = 16;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR        = 3'd0,
        SEL_LATCH      = 3'd1,
        SEL_PINS       = 3'd2,
        SEL_OPEN_DRAIN = 3'd3,
        SEL_ANALOG     = 3'd4
    } reg_sel_e;

    // drive decision for a single pin
    typedef struct packed {
        logic enable;
        logic level;
    } pin_drive_t;

    // direction 1 = input; open-drain pins only pull low
    function automatic pin_drive_t pin_drive(input logic is_input,
                                             input logic latch_bit,
                                             input logic open_drain);
        pin_drive_t d;
        if (is_input) begin
            d.enable = 1'b0;
            d.level  = 1'b0;
        end else if (open_drain) begin
            d.enable = ~latch_bit;
            d.level  = 1'b0;
        end else begin
            d.enable = 1'b1;
            d.level  = latch_bit;
        end
        return d;
    endfunction

    function automatic logic sel_is_latch(input reg_sel_e s);
        return (s == SEL_LATCH) || (s == SEL_PINS);
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  odrain_q,
    output logic [WIDTH-1:0]  analog_q
);

    reg_sel_e sel;
    logic     hit_dir;
    logic     hit_latch;
    logic     hit_od;
    logic     hit_an;

    always_comb begin
        sel       = reg_sel_e'(wr_sel);
        hit_dir   = wr_en && (sel == SEL_DIR);
        hit_latch = wr_en && sel_is_latch(sel);
        hit_od    = wr_en && (sel == SEL_OPEN_DRAIN);
        hit_an    = wr_en && (sel == SEL_ANALOG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q    <= '1;
            latch_q  <= '0;
            odrain_q <= '0;
            analog_q <= '0;
        end else begin
            if (hit_dir)   dir_q    <= wr_data;
            if (hit_latch) latch_q  <= wr_data;
            if (hit_od)    odrain_q <= wr_data;
            if (hit_an)    analog_q <= wr_data;
        end
    end

    // reset values of the control words
    assert_reset_values_R1: assert property (@(posedge clk)
        rst |=> (dir_q == '1 && latch_q == '0 && odrain_q == '0 && analog_q == '0));

    // both latch and pin addresses load the latch
    assert_latch_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_sel == SEL_PINS || wr_sel == SEL_LATCH))
            |=> latch_q == $past(wr_data));

    // writes to unmapped addresses change nothing
    assert_unmapped_write_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel > SEL_ANALOG)
            |=> ($stable(dir_q) && $stable(latch_q) && $stable(odrain_q) && $stable(analog_q)));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = PORT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] odrain_q,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pin_drive_t drv;
        always_comb begin
            drv        = pin_drive(dir_q[i], latch_q[i], odrain_q[i]);
            pad_oe[i]  = drv.enable;
            pad_out[i] = drv.level;
        end
    end

    // input pins never drive
    assert_input_tristate_R2: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & dir_q) == '0);

    // open-drain pins never drive high
    assert_od_no_high_R3: assert property (@(posedge clk) disable iff (rst)
        (pad_oe & odrain_q & pad_out) == '0);

endmodule

// File: rtl/gpio_pin_sampler.sv
module gpio_pin_sampler
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = PORT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pad_in,
    input  logic [WIDTH-1:0] analog_q,
    output logic [WIDTH-1:0] pins_view
);

    logic [WIDTH-1:0] gated_in;
    logic [WIDTH-1:0] pins_q;

    // analog pins have their digital receiver switched off
    assign gated_in = pad_in & ~analog_q;

    always_ff @(posedge clk) begin
        if (rst) pins_q <= '0;
        else     pins_q <= gated_in;
    end

    // an analog bit set after sampling still masks the read
    assign pins_view = pins_q & ~analog_q;

    assert_analog_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (pins_view & analog_q) == '0);

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_sel,
    input  logic [WIDTH-1:0]  dir_q,
    input  logic [WIDTH-1:0]  latch_q,
    input  logic [WIDTH-1:0]  pins_view,
    input  logic [WIDTH-1:0]  odrain_q,
    input  logic [WIDTH-1:0]  analog_q,
    output logic [WIDTH-1:0]  rd_data
);

    logic [WIDTH-1:0] rd_next;

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_DIR:        rd_next = dir_q;
            SEL_LATCH:      rd_next = latch_q;
            SEL_PINS:       rd_next = pins_view;
            SEL_OPEN_DRAIN: rd_next = odrain_q;
            SEL_ANALOG:     rd_next = analog_q;
            default:        rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    assert_read_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    assert_latch_readback_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_LATCH) |=> rd_data == $past(latch_q));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = PORT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] odrain_q;
    logic [WIDTH-1:0] analog_q;
    logic [WIDTH-1:0] pins_view;

    gpio_cfg_regs #(.WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (addr),
        .wr_data  (wr_data),
        .dir_q    (dir_q),
        .latch_q  (latch_q),
        .odrain_q (odrain_q),
        .analog_q (analog_q)
    );

    gpio_pad_ctrl #(.WIDTH(WIDTH)) u_pads (
        .clk      (clk),
        .rst      (rst),
        .dir_q    (dir_q),
        .latch_q  (latch_q),
        .odrain_q (odrain_q),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    gpio_pin_sampler #(.WIDTH(WIDTH)) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .pad_in    (pad_in),
        .analog_q  (analog_q),
        .pins_view (pins_view)
    );

    gpio_read_mux #(.WIDTH(WIDTH)) u_rdmux (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rd_sel    (addr),
        .dir_q     (dir_q),
        .latch_q   (latch_q),
        .pins_view (pins_view),
        .odrain_q  (odrain_q),
        .analog_q  (analog_q),
        .rd_data   (rd_data)
    );

    // analog output pins keep driving their latch
    assert_analog_output_drives_R8: assert property (@(posedge clk) disable iff (rst)
        ((analog_q & ~dir_q & ~odrain_q) & (~pad_oe | (pad_out ^ latch_q))) == '0);

endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic [W-1:0] pad_in;
    logic [W-1:0] pad_out;
    logic [W-1:0] pad_oe;
    logic [W-1:0] ext_drive = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench-side model of the control words
    logic [W-1:0] m_dir = '1, m_lat = '0, m_od = '0, m_an = '0;

    always #4 clk = ~clk;

    // pad model: block drive wins, otherwise the external level
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_drive);

    gpio_port uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [W-1:0] exp_oe();
        return ~m_dir & ~(m_od & m_lat);
    endfunction

    function automatic logic [W-1:0] exp_out();
        return ~m_dir & ~m_od & m_lat;
    endfunction

    function automatic logic [W-1:0] exp_pins();
        logic [W-1:0] lvl;
        lvl = (exp_oe() & exp_out()) | (~exp_oe() & ext_drive);
        return lvl & ~m_an;
    endfunction

    function automatic logic [W-1:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_dir;
            3'd1:    return m_lat;
            3'd2:    return exp_pins();
            3'd3:    return m_od;
            3'd4:    return m_an;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            3'd0: m_dir = d;
            3'd1, 3'd2: m_lat = d;
            3'd3: m_od = d;
            3'd4: m_an = d;
            default: ;
        endcase
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_pads(input string tag);
        check({tag, " oe"}, pad_oe, exp_oe());
        check({tag, " out"}, pad_out & pad_oe, exp_out() & exp_oe());
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [W-1:0] v;
        logic [W-1:0] prev;
        int unused_seed;
        unused_seed = $urandom(32'd7311);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(1);

        // R1: reset state
        check("R1 pad_oe", pad_oe, '0);
        check("R1 rd_data", rd_data, '0);
        for (int a = 0; a < 5; a++) begin
            rd(a[2:0], v);
            check("R1 reset readback", v, exp_read(a[2:0]));
        end

        // R2: upper half inputs, lower half outputs
        wr(3'd0, 16'hFF00);
        check("R2 pad_oe after dir", pad_oe, 16'h00FF);
        // R4: write through the pin address loads latch
        wr(3'd2, 16'h1234);
        check("R2 pad_out", pad_out & pad_oe, 16'h0034);
        rd(3'd1, v);
        check("R4 latch via pin address", v, 16'h1234);
        wr(3'd1, 16'h00C3);
        rd(3'd1, v);
        check("R4 latch via latch address", v, 16'h00C3);

        // R5: latch readback is not the pin state
        wr(3'd0, 16'hFFFF);
        ext_drive = 16'h0000;
        wr(3'd1, 16'hFFFF);
        idle(1);
        rd(3'd1, v);
        check("R5 latch word", v, 16'hFFFF);
        rd(3'd2, v);
        check("R5 pin word differs", v, 16'h0000);

        // R3: open-drain pins
        wr(3'd3, 16'h0F0F);
        wr(3'd1, 16'h3355);
        wr(3'd0, 16'h0000);
        check_pads("R3");
        check("R3 od low only", pad_out & m_od, '0);

        // R7: analog pins read zero
        wr(3'd0, 16'hFFFF);
        wr(3'd3, 16'h0000);
        ext_drive = 16'hFFFF;
        wr(3'd4, 16'h0F0F);
        idle(1);
        rd(3'd2, v);
        check("R7 analog masked", v, 16'hF0F0);

        // R8: analog pins configured as outputs still drive
        wr(3'd4, 16'hFFFF);
        wr(3'd1, 16'hA5A5);
        wr(3'd0, 16'h0000);
        check("R8 oe", pad_oe, 16'hFFFF);
        check("R8 out", pad_out, 16'hA5A5);
        idle(1);
        rd(3'd2, v);
        check("R8 pins read zero", v, 16'h0000);

        // R6: stale read after a pad change
        wr(3'd4, 16'h0000);
        wr(3'd0, 16'hFFFF);
        ext_drive = 16'h1111;
        idle(2);
        ext_drive = 16'h8888;
        rd(3'd2, v);
        check("R6 same-cycle read is stale", v, 16'h1111);
        rd(3'd2, v);
        check("R6 next read is fresh", v, 16'h8888);

        // R6: stale read right after a direction write
        wr(3'd1, 16'h00FF);
        wr(3'd0, 16'h0000);
        rd(3'd2, v);
        check("R6 read after dir write is stale", v, 16'h8888);
        rd(3'd2, v);
        check("R6 read one cycle later", v, 16'h00FF);

        // R9: unmapped addresses and read hold
        wr(3'd6, 16'hBEEF);
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            check("R9 readback after unmapped write", v, exp_read(a[2:0]));
        end
        rd(3'd1, prev);
        wr(3'd1, 16'h5A5A);
        idle(2);
        check("R9 rd_data held", rd_data, prev);

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [2:0] a;
            logic [W-1:0] d;
            a = 3'($urandom_range(0, 7));
            d = 16'($urandom);
            if (($urandom % 8) == 0) d = 16'hFF00;
            wr(a, d);
            ext_drive = 16'($urandom);
            check_pads("R2 R3 R8 random");
            idle(1);
            a = 3'($urandom_range(0, 7));
            rd(a, v);
            check("R4 R6 R7 R9 random read", v, exp_read(a));
        end

        summary();
    end

endmodule